// File: doc/BRIEF.md
# 40-bit full-duplex SPI register-access slave

This block lets a microcontroller reach a small set of 32-bit registers over a four-wire serial link. Every transaction is a fixed 40-bit frame: a header byte carrying a direction flag and a 7-bit register address, then a 32-bit data word. The slave returns a bit for every bit it receives. During the header it sends back a status byte, and during the data word it sends back read data.

Reads are pipelined. The data returned in a frame comes from the register named by the most recent completed read frame. That value was captured when that earlier frame ended. Writes take effect only when the 40th bit has been clocked in. The serial pins are oversampled by the system clock through a short synchronizer, and all frame logic runs in the system clock domain.

The register set holds four entries:
- a 32-bit control word that can be read and written;
- a 16-bit control half-word that can be read and written;
- a write-only command word;
- a read-only view of a 32-bit hardware status input.

Top module: `spi40_slave`

## Requirements
- R1: A frame is 40 bits with the most significant bit first. Frame bit 39 set to 1 selects a write and 0 selects a read. Bits 38..32 carry the register address and bits 31..0 carry the data word.
- R2: Over the first 8 bits of a frame the slave sends the status byte. Bit 7 is the aborted-frame flag, bit 6 is the unknown-address flag, and bits 5..0 are zero.
- R3: A register changes only when a write frame completes at its 40th rising serial-clock edge.
- R4: The register map is as follows. Address 0x00 is a 32-bit read/write word. Address 0x01 is read/write and holds data bits 15..0: upper bits read as zero and are dropped on write. Address 0x02 is write-only, is driven on `cmd_word`, and reads as zero. Address 0x03 is read-only, reads `hw_status`, and a write to it has no effect.
- R5: The 32 data bits returned in a frame are the value latched by the last completed read frame. Write frames and aborted frames leave this latch unchanged, and it is zero after reset.
- R6: If chip select rises before 40 bits have been clocked, no register is written and the aborted-frame flag is set. This includes a frame with zero bits. The bit count restarts at the next falling edge of chip select.
- R7: A completed frame to an address outside 0x00..0x03 sets the unknown-address flag. A read of such an address latches zero.
- R8: Both status flags are cleared at the falling edge of chip select that starts the frame which reports them.
- R9: The slave samples `spi_mosi` on rising `spi_sck` edges and updates `spi_miso` only on falling edges (SPI mode 3). `spi_miso` is held low while chip select is high.
- R10: During reset all registers and the read latch are zero, both flags are clear, and `spi_miso` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_cs_n | input | 1 | Chip select, active low, frames each transaction |
| spi_sck | input | 1 | Serial clock, idle high |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| hw_status | input | 32 | Value returned by the read-only register |
| ctrl_word | output | 32 | Read/write 32-bit control register |
| ctrl_half | output | 16 | Read/write 16-bit control register |
| cmd_word | output | 32 | Write-only command register |

## Verification
Each serial edge passes through two synchronizer stages and one edge-detect register, so a new `spi_miso` bit is due on the third system clock edge after a falling `spi_sck`. A register write is due on the third edge after the 40th rising `spi_sck`. The bench keeps every serial-clock phase eight system clocks long and samples `spi_miso` on the last cycle of each low phase, which is well after the bit is due. It reads the register ports only after chip select has been high for sixteen cycles. Status flags and read data show up one frame after the frame that caused them, so each expected value in the vector table accounts for that one-frame lag.

// File: rtl/spi40_pkg.sv
package spi40_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 32;
  localparam int HALF_W  = 16;
  localparam int HDR_W   = ADDR_W + 1;
  localparam int FRAME_W = HDR_W + DATA_W;

  localparam logic [ADDR_W-1:0] A_CTRL_WORD = 7'h00;
  localparam logic [ADDR_W-1:0] A_CTRL_HALF = 7'h01;
  localparam logic [ADDR_W-1:0] A_CMD_WORD  = 7'h02;
  localparam logic [ADDR_W-1:0] A_HW_STATUS = 7'h03;

  typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_WO, ACC_RO} acc_e;

  function automatic acc_e acc_of(input logic [ADDR_W-1:0] a);
    acc_e k;
    case (a)
      A_CTRL_WORD, A_CTRL_HALF: k = ACC_RW;
      A_CMD_WORD:               k = ACC_WO;
      A_HW_STATUS:              k = ACC_RO;
      default:                  k = ACC_NONE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/spi40_sync.sv
module spi40_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi40_frame.sv
module spi40_frame #(
  parameter int FRAME_W = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n_s,
  input  logic               sck_s,
  input  logic               mosi_s,
  input  logic [FRAME_W-1:0] tx_load,
  output logic               miso,
  output logic               cs_fall,
  output logic               frame_done,
  output logic               short_frame,
  output logic [FRAME_W-1:0] rx_word
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic               cs_q, sck_q, miso_q;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [FRAME_W-2:0] rx_q, rx_n;
  logic [FRAME_W-1:0] tx_q, tx_n;
  logic               miso_n, cs_rise, sck_rise, sck_fall;

  always_comb begin
    sck_rise    = !cs_n_s && sck_s && !sck_q;
    sck_fall    = !cs_n_s && !sck_s && sck_q;
    cs_fall     = cs_q && !cs_n_s;
    cs_rise     = !cs_q && cs_n_s;
    frame_done  = sck_rise && (cnt_q == CNT_LAST);
    short_frame = cs_rise && (cnt_q != CNT_FULL);
    rx_word     = {rx_q, mosi_s};
    cnt_n  = cnt_q;
    rx_n   = rx_q;
    tx_n   = tx_q;
    miso_n = miso_q;
    if (cs_fall) begin
      cnt_n = '0;
      tx_n  = tx_load;
    end
    if (sck_rise && (cnt_q != CNT_FULL)) begin
      rx_n  = {rx_q[FRAME_W-3:0], mosi_s};
      cnt_n = cnt_q + 1'b1;
    end
    if (sck_fall) begin
      miso_n = tx_q[FRAME_W-1];
      tx_n   = {tx_q[FRAME_W-2:0], 1'b0};
    end
    if (cs_n_s) miso_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sck_q  <= 1'b1;
      miso_q <= 1'b0;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
    end else begin
      cs_q   <= cs_n_s;
      sck_q  <= sck_s;
      miso_q <= miso_n;
      cnt_q  <= cnt_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
    end
  end

  assign miso = miso_q;
endmodule

// File: rtl/spi40_regs.sv
module spi40_regs
  import spi40_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done,
  input  logic               short_frame,
  input  logic               cs_fall,
  input  logic [FRAME_W-1:0] rx_word,
  input  logic [DATA_W-1:0]  hw_status,
  output logic [FRAME_W-1:0] tx_load,
  output logic [DATA_W-1:0]  ctrl_word,
  output logic [HALF_W-1:0]  ctrl_half,
  output logic [DATA_W-1:0]  cmd_word
);
  logic              is_wr;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rd_val;
  acc_e              acc;
  logic              en_word, en_half, en_cmd, en_rd;
  logic              abort_q, abort_n, bad_q, bad_n;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    is_wr = rx_word[FRAME_W-1];
    addr  = rx_word[FRAME_W-2:DATA_W];
    wdata = rx_word[DATA_W-1:0];
    acc   = acc_of(addr);
    case (addr)
      A_CTRL_WORD: rd_val = ctrl_word;
      A_CTRL_HALF: rd_val = {{(DATA_W-HALF_W){1'b0}}, ctrl_half};
      A_HW_STATUS: rd_val = hw_status;
      default:     rd_val = '0;
    endcase
    en_word = frame_done && is_wr && (addr == A_CTRL_WORD);
    en_half = frame_done && is_wr && (addr == A_CTRL_HALF);
    en_cmd  = frame_done && is_wr && (addr == A_CMD_WORD);
    en_rd   = frame_done && !is_wr;
    abort_n = abort_q;
    bad_n   = bad_q;
    if (frame_done && (acc == ACC_NONE)) bad_n = 1'b1;
    if (short_frame) abort_n = 1'b1;
    if (cs_fall) begin
      abort_n = 1'b0;
      bad_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_word <= '0;
      ctrl_half <= '0;
      cmd_word  <= '0;
      rd_q      <= '0;
      abort_q   <= 1'b0;
      bad_q     <= 1'b0;
    end else begin
      if (en_word) ctrl_word <= wdata;
      if (en_half) ctrl_half <= wdata[HALF_W-1:0];
      if (en_cmd)  cmd_word  <= wdata;
      if (en_rd)   rd_q      <= rd_val;
      abort_q <= abort_n;
      bad_q   <= bad_n;
    end
  end

  assign tx_load = {abort_q, bad_q, {(HDR_W-2){1'b0}}, rd_q};
endmodule

// File: rtl/spi40_slave.sv
module spi40_slave
  import spi40_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [DATA_W-1:0] hw_status,
  output logic [DATA_W-1:0] ctrl_word,
  output logic [HALF_W-1:0] ctrl_half,
  output logic [DATA_W-1:0] cmd_word
);
  logic               rst_sn;
  logic               cs_n_s, sck_s, mosi_s;
  logic               cs_fall, frame_done, short_frame;
  logic [FRAME_W-1:0] rx_word, tx_load;

  spi40_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sn)
  );

  spi40_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_pin_sync (
    .clk(clk), .rst_n(rst_sn),
    .d({spi_cs_n, spi_sck, spi_mosi}),
    .q({cs_n_s, sck_s, mosi_s})
  );

  spi40_frame #(.FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst_n(rst_sn), .cs_n_s(cs_n_s), .sck_s(sck_s), .mosi_s(mosi_s),
    .tx_load(tx_load), .miso(spi_miso), .cs_fall(cs_fall),
    .frame_done(frame_done), .short_frame(short_frame), .rx_word(rx_word)
  );

  spi40_regs u_regs (
    .clk(clk), .rst_n(rst_sn), .frame_done(frame_done), .short_frame(short_frame),
    .cs_fall(cs_fall), .rx_word(rx_word), .hw_status(hw_status), .tx_load(tx_load),
    .ctrl_word(ctrl_word), .ctrl_half(ctrl_half), .cmd_word(cmd_word)
  );
endmodule

// File: rtl/spi40_slave_chk.sv
module spi40_slave_chk
  import spi40_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n_s,
  input logic              spi_miso,
  input logic              frame_done,
  input logic              short_frame,
  input logic [1:0]        st_flags,
  input logic [DATA_W-1:0] ctrl_word,
  input logic [HALF_W-1:0] ctrl_half,
  input logic [DATA_W-1:0] cmd_word
);
  // R9: output held low once chip select is seen high
  p_miso_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n_s) |-> !spi_miso);

  // R3: registers move only on a completed frame
  p_write_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> ($stable(ctrl_word) && $stable(ctrl_half) && $stable(cmd_word)));

  // R6: short frame raises the abort flag
  p_abort_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    short_frame |=> st_flags[1]);

  // R1: completion only inside a chip-select window
  p_done_framed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !cs_n_s);

  // R8: flags cleared when a new frame begins
  p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_s) |=> (st_flags == 2'b00));
endmodule

bind spi40_slave spi40_slave_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .cs_n_s(cs_n_s), .spi_miso(spi_miso),
  .frame_done(frame_done), .short_frame(short_frame),
  .st_flags(tx_load[spi40_pkg::FRAME_W-1 -: 2]),
  .ctrl_word(ctrl_word), .ctrl_half(ctrl_half), .cmd_word(cmd_word)
);

// File: tb/spi40_slave_bench.sv
module spi40_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NVEC = 11;
  // {frame sent, frame expected back}
  localparam logic [79:0] VEC [NVEC] = '{
    {40'h80_12345678, 40'h00_00000000},
    {40'h00_00000000, 40'h00_00000000},
    {40'h81_AAAA5555, 40'h00_12345678},
    {40'h01_00000000, 40'h00_12345678},
    {40'h82_DEADBEEF, 40'h00_00005555},
    {40'h02_00000000, 40'h00_00005555},
    {40'h83_FFFFFFFF, 40'h00_00000000},
    {40'h03_00000000, 40'h00_00000000},
    {40'h05_00000000, 40'h00_CAFE0003},
    {40'h00_00000000, 40'h40_00000000},
    {40'h00_00000000, 40'h00_12345678}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1, spi_sck = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic [31:0] hw_status = 32'hCAFE_0003;
  logic [31:0] ctrl_word, cmd_word;
  logic [15:0] ctrl_half;
  int checks = 0, fails = 0;
  logic [39:0] got;

  spi40_slave u_spi40_slave (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .hw_status(hw_status),
    .ctrl_word(ctrl_word), .ctrl_half(ctrl_half), .cmd_word(cmd_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [39:0] word, input int nbits, output logic [39:0] rx);
    rx = '0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_sck = 1'b0;
      spi_mosi = word[39-i];
      repeat (HALF) @(negedge clk);
      rx[39-i] = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    repeat (2*HALF) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10: reset state
    check("R10 miso", {39'd0, spi_miso}, 40'd0);
    check("R10 ctrl_word", {8'd0, ctrl_word}, 40'd0);
    check("R10 ctrl_half", {24'd0, ctrl_half}, 40'd0);
    check("R10 cmd_word", {8'd0, cmd_word}, 40'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 R2 R4 R5 R7: vector table
    for (int i = 0; i < NVEC; i++) begin
      xfer(VEC[i][79:40], 40, got);
      check($sformatf("R2/R4/R5 vector %0d", i), got, VEC[i][39:0]);
    end
    // R3 R4: register ports after the writes
    check("R3 ctrl_word", {8'd0, ctrl_word}, 40'h00_12345678);
    check("R4 ctrl_half", {24'd0, ctrl_half}, 40'h00_00005555);
    check("R4 cmd_word", {8'd0, cmd_word}, 40'h00_DEADBEEF);
    // R9: idle output
    check("R9 miso idle", {39'd0, spi_miso}, 40'd0);

    // R6: aborted write after 20 bits
    xfer(40'h80_00000000, 20, got);
    check("R6 no write on abort", {8'd0, ctrl_word}, 40'h00_12345678);
    xfer(40'h00_00000000, 40, got);
    check("R6 abort flag", got, 40'h80_12345678);
    // R8: flag cleared after report
    xfer(40'h00_00000000, 40, got);
    check("R8 flags cleared", got, 40'h00_12345678);
    // R6: zero-bit frame
    xfer(40'h00_00000000, 0, got);
    xfer(40'h00_00000000, 40, got);
    check("R6 zero-bit frame", got, 40'h80_12345678);
    // R7: write to unknown address
    xfer(40'h90_11111111, 40, got);
    check("R7 write unknown", got, 40'h00_12345678);
    xfer(40'h00_00000000, 40, got);
    check("R7 bad address flag", got, 40'h40_12345678);
    check("R7 no side effect", {8'd0, ctrl_word}, 40'h00_12345678);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule